// File: doc/BRIEF.md
# Dual Row-Buffer DRAM Access Controller

This block controls one DRAM cell array through two page-wide row buffers used in ping-pong fashion. No bank split by address exists: either buffer may open any row of the array. The host issues word reads and writes, each naming a row and a word position within that row. While the requested row is already open in the active buffer, the request is served from that buffer alone and the array sees no command.

On a row miss the idle buffer opens the new row. It activates the row, captures it, detaches and precharges the array, and then serves the request from the freshly filled buffer, which becomes the active one. The previously active buffer is retired. If it holds modified data, its row is written back to the array afterwards, in the background, while hits on the new active buffer continue to be served. A clean retired buffer is dropped without touching the array. A second miss that arrives while a write-back still owns the array is held off with the ready signal.

Every array command also drives four half-bitline select lines. These are decoded from the two low bits of the row address on the array port.

Top module: `dual_rowbuf_ctrl`

## Requirements
- R1: After reset `rspValid` is 0, `arrCmd` is 0 (idle) and `arrHalfSel` is 0. Both buffers are empty, so the first request of any row is a miss that issues an activate.
- R2: A request whose row is open in the active buffer is accepted in the cycle it is presented and issues no array command. For a read, `rspValid` and `rspData` appear in the cycle right after acceptance.
- R3: A miss is accepted when the array is free. It then drives `arrCmd` through activate (1), load (2) and precharge (4) on three consecutive cycles. The request is served in the precharge cycle, and `reqReady` stays low during those three cycles.
- R4: When the retired buffer is dirty, the controller follows the fill's precharge with activate (1), restore (3) and precharge (4) of the retired row on three consecutive cycles. The restore cycle drives the whole retired buffer on `arrWrData`.
- R5: When the retired buffer is clean or empty, no restore command is issued.
- R6: During a write-back, hits on the active buffer are still accepted. A miss keeps `reqReady` low until the write-back's precharge cycle has passed, so a miss presented right after another miss that retires a dirty row waits six cycles.
- R7: The column field selects the 32-bit word at bits [col*32+31 : col*32] of the 256-bit row. A write changes only that word and marks the buffer dirty.
- R8: While `arrCmd` is non-zero, `arrHalfSel` has exactly two bits set, chosen by v = `arrRow[1:0]`: bits 0 and 3 for v=0, bits 0 and 1 for v=1, bits 1 and 2 for v=2, and bits 2 and 3 for v=3. When `arrCmd` is 0, it is all zero.
- R9: Every read returns the last value written to that row and word, or zero if that word was never written, under any mix of hits and misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | 9 | Row address |
| reqCol | input | 3 | Word position within the row |
| reqWdata | input | 32 | Write word |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| arrCmd | output | 3 | Array command: 0 idle, 1 activate, 2 load, 3 restore, 4 precharge |
| arrRow | output | 9 | Row addressed by the array command |
| arrHalfSel | output | 4 | Half-bitline select lines |
| arrWrData | output | 256 | Row data written on restore |
| arrRdData | input | 256 | Row data from the array, valid during load |

## Verification
The bench aims at the handover between the two buffers. It looks for a read right after a miss that sees stale buffer contents, which would show up as a word mismatch. It also looks for a dirty row that is never restored, which would make a later re-open of that row return old data. A controller that restores a clean buffer is exposed by counting restore commands. One that overlaps a second fill with a pending write-back, or that stalls hits during a write-back, is caught by counting the ready-low cycles against the fixed values of three and six. Word positions are checked in the array contents after a restore, and every array command is checked against the select-line rotation and the activate/load/restore/precharge order.

// File: rtl/drb_pkg.sv
package drb_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ACT     = 3'd1,
    CMD_LOAD    = 3'd2,
    CMD_RESTORE = 3'd3,
    CMD_PRE     = 3'd4
  } arrCmd_t;

  // strobes from control to the buffer datapath
  typedef struct packed {
    logic loadEn;    // capture array row into loadBuf
    logic loadBuf;
    logic accEn;     // word access on accBuf
    logic accWrite;
    logic accBuf;
    logic wbBuf;     // buffer driven toward the array
  } bufStrobe_t;

endpackage

// File: rtl/drb_ctrl.sv
module drb_ctrl
  import drb_pkg::*;
#(
  parameter int ROW_AW = 9,
  parameter int COL_AW = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ROW_AW-1:0] reqRow,
  input  logic [COL_AW-1:0] reqCol,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [COL_AW-1:0] accCol,
  output logic [WORD_W-1:0] accWdata,
  output arrCmd_t           arrCmd,
  output logic [ROW_AW-1:0] arrRow,
  output bufStrobe_t        strobe
);

  typedef enum logic [1:0] {F_IDLE, F_ACT, F_LOAD, F_PRE} fillSt_t;
  typedef enum logic [1:0] {W_IDLE, W_ACT, W_RES, W_PRE} wbSt_t;

  fillSt_t fillSt;
  wbSt_t   wbSt;

  logic [1:0]        bufValid;
  logic [1:0]        bufDirty;
  logic [ROW_AW-1:0] bufTag [2];
  logic              actBuf;
  logic              oldBuf;

  logic              pendWrite;
  logic [COL_AW-1:0] pendCol;
  logic [WORD_W-1:0] pendWdata;

  logic hit;
  logic acceptHit;
  logic acceptMiss;
  logic serveFill;

  assign oldBuf     = ~actBuf;
  assign hit        = bufValid[actBuf] && (bufTag[actBuf] == reqRow);
  assign reqReady   = (fillSt == F_IDLE) && (hit || (wbSt == W_IDLE));
  assign acceptHit  = reqValid && reqReady && hit;
  assign acceptMiss = reqValid && reqReady && !hit;
  assign serveFill  = (fillSt == F_PRE);

  // access and strobe selection
  always_comb begin
    strobe          = '0;
    strobe.wbBuf    = oldBuf;
    strobe.loadBuf  = actBuf;
    strobe.loadEn   = (fillSt == F_LOAD);
    accCol          = reqCol;
    accWdata        = reqWdata;
    if (serveFill) begin
      strobe.accEn    = 1'b1;
      strobe.accWrite = pendWrite;
      strobe.accBuf   = actBuf;
      accCol          = pendCol;
      accWdata        = pendWdata;
    end else if (acceptHit) begin
      strobe.accEn    = 1'b1;
      strobe.accWrite = reqWrite;
      strobe.accBuf   = actBuf;
    end
  end

  // array command: the fill owns the array, then the write-back
  always_comb begin
    arrCmd = CMD_NOP;
    arrRow = bufTag[oldBuf];
    unique case (fillSt)
      F_ACT:   arrCmd = CMD_ACT;
      F_LOAD:  arrCmd = CMD_LOAD;
      F_PRE:   arrCmd = CMD_PRE;
      default: ;
    endcase
    if (fillSt != F_IDLE) begin
      arrRow = bufTag[actBuf];
    end else begin
      unique case (wbSt)
        W_ACT:   arrCmd = CMD_ACT;
        W_RES:   arrCmd = CMD_RESTORE;
        W_PRE:   arrCmd = CMD_PRE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillSt    <= F_IDLE;
      wbSt      <= W_IDLE;
      bufValid  <= '0;
      bufDirty  <= '0;
      bufTag[0] <= '0;
      bufTag[1] <= '0;
      actBuf    <= 1'b0;
      pendWrite <= 1'b0;
      pendCol   <= '0;
      pendWdata <= '0;
      rspValid  <= 1'b0;
    end else begin
      rspValid <= strobe.accEn && !strobe.accWrite;

      if (strobe.accEn && strobe.accWrite) begin
        bufDirty[actBuf] <= 1'b1;
      end

      unique case (fillSt)
        F_IDLE: begin
          if (acceptMiss) begin
            actBuf           <= oldBuf;
            bufTag[oldBuf]   <= reqRow;
            bufValid[oldBuf] <= 1'b0;
            bufDirty[oldBuf] <= 1'b0;
            pendWrite        <= reqWrite;
            pendCol          <= reqCol;
            pendWdata        <= reqWdata;
            fillSt           <= F_ACT;
          end
        end
        F_ACT:  fillSt <= F_LOAD;
        F_LOAD: begin
          bufValid[actBuf] <= 1'b1;
          fillSt           <= F_PRE;
        end
        F_PRE: begin
          fillSt <= F_IDLE;
          if (bufValid[oldBuf] && bufDirty[oldBuf]) begin
            wbSt <= W_ACT;
          end
        end
        default: fillSt <= F_IDLE;
      endcase

      unique case (wbSt)
        W_ACT: wbSt <= W_RES;
        W_RES: wbSt <= W_PRE;
        W_PRE: begin
          bufDirty[oldBuf] <= 1'b0;
          wbSt             <= W_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R3
  property loadAfterAct;
    @(posedge clk) disable iff (!rstN)
      (arrCmd == CMD_LOAD) |-> ($past(arrCmd) == CMD_ACT);
  endproperty
  load_after_act_chk: assert property (loadAfterAct);

  // R4
  property restoreAfterAct;
    @(posedge clk) disable iff (!rstN)
      (arrCmd == CMD_RESTORE) |-> ($past(arrCmd) == CMD_ACT);
  endproperty
  restore_after_act_chk: assert property (restoreAfterAct);

  // R5
  property cleanSkip;
    @(posedge clk) disable iff (!rstN)
      (fillSt == F_PRE && !bufDirty[oldBuf]) |=> (arrCmd != CMD_ACT);
  endproperty
  clean_skip_chk: assert property (cleanSkip);

  // R2
  property hitReadLatency;
    @(posedge clk) disable iff (!rstN)
      (reqValid && reqReady && hit && !reqWrite && fillSt == F_IDLE) |=> rspValid;
  endproperty
  hit_read_latency_chk: assert property (hitReadLatency);

  // R6
  property hitDuringWb;
    @(posedge clk) disable iff (!rstN)
      (reqValid && hit && fillSt == F_IDLE && wbSt != W_IDLE) |-> reqReady;
  endproperty
  hit_during_wb_chk: assert property (hitDuringWb);

endmodule

// File: rtl/drb_datapath.sv
module drb_datapath
  import drb_pkg::*;
#(
  parameter int ROW_W    = 256,
  parameter int WORD_W   = 32,
  parameter int COL_AW   = 3,
  parameter int SEL_BITS = 2,
  localparam int NUM_SEL = 1 << SEL_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  bufStrobe_t          strobe,
  input  logic [COL_AW-1:0]   accCol,
  input  logic [WORD_W-1:0]   accWdata,
  input  arrCmd_t             arrCmd,
  input  logic [SEL_BITS-1:0] rowLsb,
  input  logic [ROW_W-1:0]    arrRdData,
  output logic [ROW_W-1:0]    arrWrData,
  output logic [NUM_SEL-1:0]  arrHalfSel,
  output logic [WORD_W-1:0]   rspData
);

  logic [ROW_W-1:0] rowBuf [2];

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (strobe.loadEn && (strobe.loadBuf == 1'(b))) begin
        rowBuf[b] <= arrRdData;
      end else if (strobe.accEn && strobe.accWrite && (strobe.accBuf == 1'(b))) begin
        rowBuf[b][accCol*WORD_W +: WORD_W] <= accWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
    end else if (strobe.accEn && !strobe.accWrite) begin
      rspData <= rowBuf[strobe.accBuf][accCol*WORD_W +: WORD_W];
    end
  end

  assign arrWrData = rowBuf[strobe.wbBuf];

  // rotating pair of half-bitline selects
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign arrHalfSel[i] = (arrCmd != CMD_NOP) &&
                           ((rowLsb == SEL_BITS'(i)) ||
                            (rowLsb == SEL_BITS'((i + 1) % NUM_SEL)));
  end

  // R8
  property selPair;
    @(posedge clk) disable iff (!rstN)
      (arrCmd != CMD_NOP) |-> ($countones(arrHalfSel) == 2);
  endproperty
  sel_pair_chk: assert property (selPair);

  // R8
  property selIdle;
    @(posedge clk) disable iff (!rstN)
      (arrCmd == CMD_NOP) |-> (arrHalfSel == '0);
  endproperty
  sel_idle_chk: assert property (selIdle);

endmodule

// File: rtl/dual_rowbuf_ctrl.sv
module dual_rowbuf_ctrl
  import drb_pkg::*;
#(
  parameter int ROW_W    = 256,
  parameter int NUM_ROWS = 512,
  parameter int WORD_W   = 32,
  parameter int SEL_BITS = 2,
  localparam int ROW_AW  = $clog2(NUM_ROWS),
  localparam int COL_AW  = $clog2(ROW_W / WORD_W),
  localparam int NUM_SEL = 1 << SEL_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ROW_AW-1:0]  reqRow,
  input  logic [COL_AW-1:0]  reqCol,
  input  logic [WORD_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [WORD_W-1:0]  rspData,
  output logic [2:0]         arrCmd,
  output logic [ROW_AW-1:0]  arrRow,
  output logic [NUM_SEL-1:0] arrHalfSel,
  output logic [ROW_W-1:0]   arrWrData,
  input  logic [ROW_W-1:0]   arrRdData
);

  bufStrobe_t        strobe;
  arrCmd_t           cmdInt;
  logic [COL_AW-1:0] accCol;
  logic [WORD_W-1:0] accWdata;

  assign arrCmd = cmdInt;

  drb_ctrl #(
    .ROW_AW(ROW_AW),
    .COL_AW(COL_AW),
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .accCol   (accCol),
    .accWdata (accWdata),
    .arrCmd   (cmdInt),
    .arrRow   (arrRow),
    .strobe   (strobe)
  );

  drb_datapath #(
    .ROW_W   (ROW_W),
    .WORD_W  (WORD_W),
    .COL_AW  (COL_AW),
    .SEL_BITS(SEL_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .accCol    (accCol),
    .accWdata  (accWdata),
    .arrCmd    (cmdInt),
    .rowLsb    (arrRow[SEL_BITS-1:0]),
    .arrRdData (arrRdData),
    .arrWrData (arrWrData),
    .arrHalfSel(arrHalfSel),
    .rspData   (rspData)
  );

endmodule

// File: tb/dual_rowbuf_ctrl_test.sv
module dual_rowbuf_ctrl_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic         reqWrite = 1'b0;
  logic [8:0]   reqRow = '0;
  logic [2:0]   reqCol = '0;
  logic [31:0]  reqWdata = '0;
  logic         rspValid;
  logic [31:0]  rspData;
  logic [2:0]   arrCmd;
  logic [8:0]   arrRow;
  logic [3:0]   arrHalfSel;
  logic [255:0] arrWrData;
  logic [255:0] arrRdData = '0;

  int total = 0;
  int bad = 0;
  int actCnt = 0;
  int restoreCnt = 0;
  bit finished = 0;

  logic [255:0] arrMem [int];
  logic [31:0]  refMem [int];
  logic [31:0]  expQ [$];
  int           openRow = 0;
  logic [2:0]   prevCmd = 3'd0;

  always #5 clk = ~clk;

  dual_rowbuf_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .arrCmd(arrCmd), .arrRow(arrRow),
    .arrHalfSel(arrHalfSel), .arrWrData(arrWrData), .arrRdData(arrRdData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] memRow(input int r);
    if (arrMem.exists(r)) return arrMem[r];
    return '0;
  endfunction

  function automatic logic [31:0] refWord(input int r, input int c);
    if (refMem.exists(r * 8 + c)) return refMem[r * 8 + c];
    return '0;
  endfunction

  // behavioural array
  always @(posedge clk) begin
    if (rstN) begin
      case (arrCmd)
        3'd1: begin
          openRow   <= int'(arrRow);
          arrRdData <= memRow(int'(arrRow));
          actCnt    <= actCnt + 1;
        end
        3'd3: begin
          arrMem[openRow] = arrWrData;
          restoreCnt <= restoreCnt + 1;
        end
        default: ;
      endcase
    end
  end

  // monitor: responses, command order, select lines
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected response", rspData, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R9 read data", rspData, e);
        end
      end
      if (arrCmd == 3'd2) check(prevCmd == 3'd1, "R3 load follows activate", prevCmd, 1);
      if (arrCmd == 3'd3) check(prevCmd == 3'd1, "R4 restore follows activate", prevCmd, 1);
      if (arrCmd == 3'd4) check(prevCmd == 3'd2 || prevCmd == 3'd3, "R3 precharge follows load/restore", prevCmd, 2);
      if (arrCmd != 3'd0) begin
        int v;
        logic [3:0] es;
        v  = int'(arrRow[1:0]);
        es = 4'((1 << v) | (1 << ((v + 3) % 4)));
        check(arrHalfSel == es, "R8 half select", arrHalfSel, es);
      end else begin
        check(arrHalfSel == 4'd0, "R8 half select idle", arrHalfSel, 0);
      end
      prevCmd <= arrCmd;
    end
  end

  task automatic doReq(input bit w, input int row, input int col, input logic [31:0] d, output int stalls);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = w;
    reqRow   = 9'(row);
    reqCol   = 3'(col);
    reqWdata = d;
    stalls   = 0;
    #1;
    while (!reqReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    if (w) refMem[row * 8 + col] = d;
    else   expQ.push_back(refWord(row, col));
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st;
    int a0;
    logic [255:0] r;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1
    check(rspValid == 1'b0, "R1 reset rspValid", rspValid, 0);
    check(arrCmd == 3'd0, "R1 reset arrCmd", arrCmd, 0);
    check(arrHalfSel == 4'd0, "R1 reset arrHalfSel", arrHalfSel, 0);
    rstN = 1'b1;

    doReq(1, 5, 2, 32'hCAFE0005, st);
    check(st == 0, "R1 first request accepted at once", st, 0);
    doReq(0, 5, 2, 0, st);
    check(st == 3, "R3 stall during fill", st, 3);
    check(actCnt == 1, "R1 first request activates", actCnt, 1);
    repeat (4) @(negedge clk);
    a0 = actCnt;
    doReq(0, 5, 7, 0, st);
    check(rspValid == 1'b1, "R2 hit read latency", rspValid, 1);
    check(st == 0, "R2 hit no stall", st, 0);
    repeat (4) @(negedge clk);
    check(actCnt == a0, "R2 hit issues no array command", actCnt, a0);
    check(restoreCnt == 0, "R5 empty retire no restore", restoreCnt, 0);

    doReq(0, 6, 2, 0, st);
    check(st == 0, "R3 miss accepted when array free", st, 0);
    doReq(0, 7, 1, 0, st);
    check(st == 6, "R6 miss waits for write-back", st, 6);
    repeat (10) @(negedge clk);
    check(restoreCnt == 1, "R4 dirty row restored, R5 clean skipped", restoreCnt, 1);
    r = memRow(5);
    check(r[95:64] == 32'hCAFE0005, "R4 restored word", r[95:64], 32'hCAFE0005);
    doReq(0, 5, 2, 0, st);

    doReq(1, 5, 3, 32'h1234ABCD, st);
    doReq(0, 8, 0, 0, st);
    doReq(0, 8, 1, 0, st);
    check(st == 3, "R6 hit accepted during write-back", st, 3);
    repeat (10) @(negedge clk);
    check(restoreCnt == 2, "R4 second restore", restoreCnt, 2);

    doReq(1, 9, 0, 32'hAAAA0000, st);
    doReq(1, 9, 7, 32'hBBBB7777, st);
    doReq(0, 9, 0, 0, st);
    doReq(0, 9, 7, 0, st);
    doReq(0, 9, 3, 0, st);
    doReq(0, 10, 0, 0, st);
    repeat (10) @(negedge clk);
    r = memRow(9);
    check(r[31:0] == 32'hAAAA0000, "R7 word 0 position", r[31:0], 32'hAAAA0000);
    check(r[255:224] == 32'hBBBB7777, "R7 word 7 position", r[255:224], 32'hBBBB7777);
    check(r[127:96] == 32'h0, "R7 untouched word", r[127:96], 0);

    // R9 random mix of hits and misses
    for (int i = 0; i < 400; i++) begin
      int row;
      int col;
      bit w;
      row = 5 + int'($urandom_range(0, 5));
      col = int'($urandom_range(0, 7));
      w   = ($urandom_range(0, 2) == 0);
      doReq(w, row, col, $urandom, st);
      if ($urandom_range(0, 3) == 0) begin
        doReq(0, row, int'($urandom_range(0, 7)), 0, st);
      end
    end
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R9 all reads answered", expQ.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule